// File: doc/BRIEF.md
# Configuration Packet Stream Parser

This block sits on a stream of 32-bit configuration words and turns it into decoded register accesses. It stays silent until a fixed synchronisation word arrives. After that it reads each word as a packet header or as payload belonging to the last header. Every header is reported with its kind, operation, target register and word count. The block keeps its own copy of the current frame address. Each word written to the frame data register is reported together with that address and a word index, so logic further down can find the bits of a given frame word.

The stream this block expects is a debug-style one. Each frame arrives in a packet of its own. After every frame data write, the stream writes the current frame address to an echo register. The parser compares each echo word with the address it is tracking and keeps a sticky flag if the two ever differ. Long data blocks use a second header kind. That header only makes sense straight after a first-kind write header with a zero count. Any other use of it raises a sticky sequence-error flag.

The input handshake is always ready once reset is released. All outputs are registered and appear in the cycle after the word is accepted.

Top module: `cfgpkt_parser`

## Requirements
- R1: One clock edge after reset is released, `in_ready` is 1. `hdr_valid`, `frm_valid`, `synced`, `echo_mismatch` and `seq_err` are all 0.
- R2: Every accepted word is ignored until the word 0xAA995566 has been accepted. Ignored words raise neither `hdr_valid` nor `frm_valid`. `synced` goes to 1 in the cycle after the sync word is accepted and stays at 1 until reset.
- R3: Once synced, a header word produces a one-cycle `hdr_valid` pulse in the next cycle. The fields are decoded as follows:
  - `hdr_type` = bits [31:29], where 1 is the short kind and 2 is the long kind.
  - `hdr_op` = bits [28:27], where 0 is no-op, 1 is read and 2 is write.
  - `hdr_reg` = bits [17:13] for the short kind, and 0 for the long kind.
  - `hdr_count` = bits [10:0] for the short kind, and bits [26:0] for the long kind.
- R4: A short-kind write header with count N>0 makes the next N accepted words payload for its register, and none of them raises `hdr_valid`. Read and no-op headers carry no payload, so the next word is again a header.
- R5: A payload word for register 1 (frame address) becomes the tracked frame address and resets the frame word index to 0.
- R6: A payload word for register 2 (frame data) produces a one-cycle `frm_valid` pulse carrying the tracked frame address, the current word index and the data word.
- R7: The word index rises by one with each frame data word. After reaching 40 it wraps to 0, because a frame is 41 words.
- R8: A long-kind write header that directly follows a short-kind write header with count 0 takes that header's register. Its 27-bit count gives the number of payload words. This does not set `seq_err`.
- R9: A long-kind header in any other position sets the sticky `seq_err` and carries no payload.
- R10: A payload word for register 12 (address echo) that differs from the tracked frame address sets the sticky `echo_mismatch`. An equal echo leaves the flag unchanged.
- R11: Payload for any other register is consumed without changing the tracked frame address or the word index.
- R12: A cycle with `in_valid` low consumes nothing, and the next cycle shows neither `hdr_valid` nor `frm_valid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input word valid |
| in_ready | output | 1 | Parser accepts a word |
| in_data | input | 32 | Input stream word |
| hdr_valid | output | 1 | Decoded header pulse |
| hdr_type | output | 3 | Header kind |
| hdr_op | output | 2 | Header operation |
| hdr_reg | output | 5 | Header register select |
| hdr_count | output | 27 | Header word count |
| frm_valid | output | 1 | Frame data word pulse |
| frm_addr | output | 32 | Tracked frame address for the word |
| frm_idx | output | 6 | Word index inside the frame |
| frm_data | output | 32 | Frame data word |
| synced | output | 1 | Sync word has been seen |
| echo_mismatch | output | 1 | Sticky echo compare failure |
| seq_err | output | 1 | Sticky illegal long-header flag |

## Verification
The bench sends a valid header before the sync word; a parser that does not gate on sync would report it or open a payload. It runs a long block of 45 frame words through a long-kind header to cross the 41-word wrap; an off-by-one wrap would report index 41 or wrap one word early. It also sends a read header followed by a no-op, sends payload to an unrelated register ahead of a frame word, and places a long-kind header after a no-op. A parser that treated read counts as payload, let foreign writes disturb the address, or accepted the stray long header would miss a header pulse, report a wrong address, or leave the error flag clear. Equal and unequal echo words check that only a real difference sets the mismatch flag and that it stays set.

// File: rtl/cfgpkt_pkg.sv
package cfgpkt_pkg;
    localparam int WORD_W   = 32;
    localparam int TYPE_MSB = 31;
    localparam int TYPE_LSB = 29;
    localparam int OP_MSB   = 28;
    localparam int OP_LSB   = 27;
    localparam int REG_MSB  = 17;
    localparam int REG_LSB  = 13;
    localparam int CNT1_W   = 11;
    localparam int CNT2_W   = 27;
    localparam int REG_W    = REG_MSB - REG_LSB + 1;
    localparam int TYPE_W   = TYPE_MSB - TYPE_LSB + 1;

    typedef enum logic [1:0] {
        OP_NOP = 2'd0,
        OP_RD  = 2'd1,
        OP_WR  = 2'd2,
        OP_RSV = 2'd3
    } op_e;

    typedef enum logic [1:0] {
        ST_HUNT = 2'd0,
        ST_HDR  = 2'd1,
        ST_BODY = 2'd2
    } st_e;

    typedef struct packed {
        logic [TYPE_W-1:0] htype;
        op_e               op;
        logic [REG_W-1:0]  regsel;
        logic [CNT2_W-1:0] count;
        logic              is_short;
        logic              is_long;
    } hdr_t;
endpackage

// File: rtl/cfgpkt_hdr_dec.sv
module cfgpkt_hdr_dec
    import cfgpkt_pkg::*;
(
    input  logic [WORD_W-1:0] word,
    output hdr_t              hdr
);
    always_comb begin
        hdr.htype    = word[TYPE_MSB:TYPE_LSB];
        hdr.op       = op_e'(word[OP_MSB:OP_LSB]);
        hdr.is_short = (hdr.htype == TYPE_W'(1));
        hdr.is_long  = (hdr.htype == TYPE_W'(2));
        if (hdr.is_long) begin
            hdr.regsel = '0;
            hdr.count  = word[CNT2_W-1:0];
        end else begin
            hdr.regsel = word[REG_MSB:REG_LSB];
            hdr.count  = {{(CNT2_W-CNT1_W){1'b0}}, word[CNT1_W-1:0]};
        end
    end
endmodule

// File: rtl/cfgpkt_idx_ctr.sv
module cfgpkt_idx_ctr #(
    parameter int DEPTH = 41,
    localparam int IDX_W = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             step,
    output logic [IDX_W-1:0] idx
);
    logic [IDX_W-1:0] idx_d, idx_q;

    always_comb begin
        idx_d = idx_q;
        if (clr) begin
            idx_d = '0;
        end else if (step) begin
            idx_d = (idx_q == IDX_W'(DEPTH-1)) ? '0 : idx_q + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) idx_q <= '0;
        else        idx_q <= idx_d;
    end

    assign idx = idx_q;
endmodule

// File: rtl/cfgpkt_parser.sv
module cfgpkt_parser
    import cfgpkt_pkg::*;
#(
    parameter int               FRAME_WORDS = 41,
    parameter logic [WORD_W-1:0] SYNC_WORD  = 32'hAA995566,
    parameter logic [REG_W-1:0]  FAR_REG    = 5'd1,
    parameter logic [REG_W-1:0]  FDATA_REG  = 5'd2,
    parameter logic [REG_W-1:0]  ECHO_REG   = 5'd12,
    localparam int IDX_W = $clog2(FRAME_WORDS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [WORD_W-1:0] in_data,
    output logic              hdr_valid,
    output logic [TYPE_W-1:0] hdr_type,
    output logic [1:0]        hdr_op,
    output logic [REG_W-1:0]  hdr_reg,
    output logic [CNT2_W-1:0] hdr_count,
    output logic              frm_valid,
    output logic [WORD_W-1:0] frm_addr,
    output logic [IDX_W-1:0]  frm_idx,
    output logic [WORD_W-1:0] frm_data,
    output logic              synced,
    output logic              echo_mismatch,
    output logic              seq_err
);
    typedef struct packed {
        st_e               st;
        logic              rdy;
        logic [WORD_W-1:0] far;
        logic [REG_W-1:0]  tgt;
        logic [CNT2_W-1:0] left;
        logic              long_ok;
        logic [REG_W-1:0]  long_reg;
        logic              hv;
        logic [TYPE_W-1:0] htype;
        logic [1:0]        hop;
        logic [REG_W-1:0]  hreg;
        logic [CNT2_W-1:0] hcnt;
        logic              fv;
        logic [WORD_W-1:0] faddr;
        logic [IDX_W-1:0]  fidx;
        logic [WORD_W-1:0] fdata;
        logic              mism;
        logic              serr;
    } state_t;

    state_t s_d, s_q;
    hdr_t   dec;
    logic   acc;
    logic   in_body;
    logic [IDX_W-1:0] idx_now;

    cfgpkt_hdr_dec u_dec (
        .word (in_data),
        .hdr  (dec)
    );

    assign acc     = in_valid && s_q.rdy;
    assign in_body = acc && (s_q.st == ST_BODY);

    cfgpkt_idx_ctr #(.DEPTH(FRAME_WORDS)) u_idx (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (in_body && (s_q.tgt == FAR_REG)),
        .step  (in_body && (s_q.tgt == FDATA_REG)),
        .idx   (idx_now)
    );

    always_comb begin
        s_d     = s_q;
        s_d.rdy = 1'b1;
        s_d.hv  = 1'b0;
        s_d.fv  = 1'b0;
        if (acc) begin
            unique case (s_q.st)
                ST_HUNT: begin
                    if (in_data == SYNC_WORD) s_d.st = ST_HDR;
                end
                ST_HDR: begin
                    s_d.hv      = 1'b1;
                    s_d.htype   = dec.htype;
                    s_d.hop     = dec.op;
                    s_d.hreg    = dec.regsel;
                    s_d.hcnt    = dec.count;
                    s_d.long_ok = 1'b0;
                    if (dec.is_short && dec.op == OP_WR) begin
                        if (dec.count == '0) begin
                            s_d.long_ok  = 1'b1;
                            s_d.long_reg = dec.regsel;
                        end else begin
                            s_d.tgt  = dec.regsel;
                            s_d.left = dec.count;
                            s_d.st   = ST_BODY;
                        end
                    end else if (dec.is_long) begin
                        if (s_q.long_ok && dec.op == OP_WR) begin
                            if (dec.count != '0) begin
                                s_d.tgt  = s_q.long_reg;
                                s_d.left = dec.count;
                                s_d.st   = ST_BODY;
                            end
                        end else begin
                            s_d.serr = 1'b1;
                        end
                    end
                end
                ST_BODY: begin
                    if (s_q.tgt == FAR_REG) begin
                        s_d.far = in_data;
                    end else if (s_q.tgt == FDATA_REG) begin
                        s_d.fv    = 1'b1;
                        s_d.faddr = s_q.far;
                        s_d.fidx  = idx_now;
                        s_d.fdata = in_data;
                    end else if (s_q.tgt == ECHO_REG) begin
                        if (in_data != s_q.far) s_d.mism = 1'b1;
                    end
                    s_d.left = s_q.left - 1'b1;
                    if (s_q.left == CNT2_W'(1)) s_d.st = ST_HDR;
                end
                default: s_d.st = ST_HUNT;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q    <= '0;
            s_q.st <= ST_HUNT;
        end else begin
            s_q <= s_d;
        end
    end

    assign in_ready      = s_q.rdy;
    assign hdr_valid     = s_q.hv;
    assign hdr_type      = s_q.htype;
    assign hdr_op        = s_q.hop;
    assign hdr_reg       = s_q.hreg;
    assign hdr_count     = s_q.hcnt;
    assign frm_valid     = s_q.fv;
    assign frm_addr      = s_q.faddr;
    assign frm_idx       = s_q.fidx;
    assign frm_data      = s_q.fdata;
    assign synced        = (s_q.st != ST_HUNT);
    assign echo_mismatch = s_q.mism;
    assign seq_err       = s_q.serr;
endmodule

// File: rtl/cfgpkt_parser_chk.sv
module cfgpkt_parser_chk #(
    parameter int FRAME_WORDS = 41,
    localparam int IDX_W = $clog2(FRAME_WORDS)
) (
    input logic             clk,
    input logic             rst_n,
    input logic             in_valid,
    input logic             in_ready,
    input logic             hdr_valid,
    input logic             frm_valid,
    input logic [IDX_W-1:0] frm_idx,
    input logic             synced,
    input logic             echo_mismatch,
    input logic             seq_err
);
    // R1
    ready_after_reset_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> in_ready);

    // R2
    silent_before_sync_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !synced |-> (!hdr_valid && !frm_valid));

    // R2
    sync_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        synced |=> synced);

    // R7
    idx_in_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        frm_valid |-> (frm_idx < IDX_W'(FRAME_WORDS)));

    // R7
    idx_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (frm_valid && $past(frm_valid)) |->
        (frm_idx == (($past(frm_idx) == IDX_W'(FRAME_WORDS-1)) ? '0 : $past(frm_idx) + 1'b1)));

    // R9
    seq_err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        seq_err |=> seq_err);

    // R10
    mismatch_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        echo_mismatch |=> echo_mismatch);

    // R12
    idle_no_output_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> (!hdr_valid && !frm_valid));
endmodule

bind cfgpkt_parser cfgpkt_parser_chk #(.FRAME_WORDS(FRAME_WORDS)) u_chk (.*);

// File: tb/cfgpkt_parser_tb.sv
module cfgpkt_parser_tb;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [31:0] in_data = '0;
    logic        in_ready, hdr_valid, frm_valid, synced, echo_mismatch, seq_err;
    logic [2:0]  hdr_type;
    logic [1:0]  hdr_op;
    logic [4:0]  hdr_reg;
    logic [26:0] hdr_count;
    logic [31:0] frm_addr, frm_data;
    logic [5:0]  frm_idx;

    int total = 0;
    int bad = 0;
    bit done = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    cfgpkt_parser u_dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
        .in_data(in_data), .hdr_valid(hdr_valid), .hdr_type(hdr_type),
        .hdr_op(hdr_op), .hdr_reg(hdr_reg), .hdr_count(hdr_count),
        .frm_valid(frm_valid), .frm_addr(frm_addr), .frm_idx(frm_idx),
        .frm_data(frm_data), .synced(synced), .echo_mismatch(echo_mismatch),
        .seq_err(seq_err)
    );

    function automatic logic [31:0] shdr(input logic [1:0] op, input logic [4:0] rg,
                                         input logic [10:0] cnt);
        return {3'b001, op, 9'b0, rg, 2'b0, cnt};
    endfunction

    function automatic logic [31:0] lhdr(input logic [1:0] op, input logic [26:0] cnt);
        return {3'b010, op, cnt};
    endfunction

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Drive one word; on return outputs reflect that word.
    task automatic send(input logic [31:0] w);
        @(negedge clk);
        in_valid = 1'b1;
        in_data  = w;
        @(posedge clk);
        #1;
        in_valid = 1'b0;
    endtask

    task automatic t_reset;
        rst_n = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        @(posedge clk);
        #1;
        chk("R1 ready", in_ready, 1);
        chk("R1 hdr_valid", hdr_valid, 0);
        chk("R1 frm_valid", frm_valid, 0);
        chk("R1 flags", {synced, echo_mismatch, seq_err}, 0);
    endtask

    task automatic t_sync;
        send(shdr(2'd2, 5'd1, 11'd1));
        chk("R2 no hdr before sync", hdr_valid, 0);
        send(32'h0000_1234);
        chk("R2 no frame before sync", frm_valid, 0);
        chk("R2 not synced", synced, 0);
        send(32'hAA995566);
        chk("R2 synced", synced, 1);
        chk("R2 sync not a header", hdr_valid, 0);
    endtask

    task automatic t_decode;
        send(shdr(2'd1, 5'd7, 11'd5));
        chk("R3 hdr_valid", hdr_valid, 1);
        chk("R3 fields", {hdr_type, hdr_op, hdr_reg}, {3'd1, 2'd1, 5'd7});
        chk("R3 count", hdr_count, 5);
        send(shdr(2'd0, 5'd0, 11'd0));
        chk("R4 read has no payload", hdr_valid, 1);
        chk("R3 nop op", hdr_op, 0);
        @(posedge clk);
        #1;
        chk("R12 idle no header", hdr_valid, 0);
        chk("R12 idle no frame", frm_valid, 0);
    endtask

    task automatic t_frame;
        send(shdr(2'd2, 5'd1, 11'd1));
        send(32'h0040_1A00);
        chk("R4 payload not header", hdr_valid, 0);
        chk("R5 far write no frame", frm_valid, 0);
        send(shdr(2'd2, 5'd2, 11'd3));
        for (int i = 0; i < 3; i++) begin
            send(32'hC0DE_0000 + i);
            chk("R6 frm_valid", frm_valid, 1);
            chk("R4 payload not header", hdr_valid, 0);
            chk("R6 addr", frm_addr, 32'h0040_1A00);
            chk("R6 idx", frm_idx, i);
            chk("R6 data", frm_data, 32'hC0DE_0000 + i);
        end
        send(shdr(2'd0, 5'd0, 11'd0));
        chk("R4 header after payload", hdr_valid, 1);
    endtask

    task automatic t_long;
        send(shdr(2'd2, 5'd1, 11'd1));
        send(32'h0040_1A80);
        send(shdr(2'd2, 5'd2, 11'd0));
        send(lhdr(2'd2, 27'd45));
        chk("R8 long type", hdr_type, 2);
        chk("R8 long count", hdr_count, 45);
        chk("R3 long reg zero", hdr_reg, 0);
        for (int i = 0; i < 45; i++) begin
            send(32'h5A00_0000 + i);
            chk("R8 long payload frame", frm_valid, 1);
            chk("R7 idx wrap", frm_idx, i % 41);
            chk("R5 addr", frm_addr, 32'h0040_1A80);
        end
        chk("R8 no seq err", seq_err, 0);
    endtask

    task automatic t_echo;
        send(shdr(2'd2, 5'd12, 11'd1));
        send(32'h0040_1A80);
        chk("R10 equal echo", echo_mismatch, 0);
        send(shdr(2'd2, 5'd12, 11'd1));
        send(32'h0040_1A81);
        chk("R10 differing echo", echo_mismatch, 1);
        send(shdr(2'd0, 5'd0, 11'd0));
        chk("R10 sticky", echo_mismatch, 1);
    endtask

    task automatic t_other;
        send(shdr(2'd2, 5'd4, 11'd2));
        send(32'hDEAD_BEEF);
        chk("R11 no header in payload", hdr_valid, 0);
        send(32'hFFFF_0000);
        chk("R11 no frame", frm_valid, 0);
        send(shdr(2'd2, 5'd2, 11'd1));
        send(32'h1111_2222);
        chk("R11 addr kept", frm_addr, 32'h0040_1A80);
        chk("R11 idx kept", frm_idx, 45 % 41);
    endtask

    task automatic t_seq;
        send(shdr(2'd0, 5'd0, 11'd0));
        chk("R9 clean before", seq_err, 0);
        send(lhdr(2'd2, 27'd3));
        chk("R9 stray long header", seq_err, 1);
        send(shdr(2'd0, 5'd0, 11'd0));
        chk("R9 no payload taken", hdr_valid, 1);
        chk("R9 sticky", seq_err, 1);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1;
            total++;
            bad++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        t_reset();
        t_sync();
        t_decode();
        t_frame();
        t_long();
        t_echo();
        t_other();
        t_seq();
        repeat (2) @(posedge clk);
        if (!done) begin
            done = 1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule